// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers six interrupt sources into a pending-request register and hands one of them to the processor at a time. Each source owns one pending bit. Software can read the pending register and poll it, or it can rely on the vectored grant. An 8-bit mask register holds one enable for each source. Its top bit is a master enable that gates every source at once. Enable and disable commands set and clear that master bit.

Three sources come from external pins. A rising edge on a pin is latched asynchronously by a capture flip-flop. Two clocked stages then bring the request into the clock domain, and the last stage sets the pending bit. The capture flip-flop clears itself once its request has gone through, so each edge gives exactly one request.

When an enabled source is pending, the block runs an acknowledge cycle. It pulses a strobe for one cycle, presents the 3-bit index of the granted source, and clears that source's pending bit. In the same cycle it clears the master enable, so that no further grant can follow until software enables interrupts again. Saving the program counter and flags belongs to the processor, not to this block.

Top module: `vint_ctrl`

## Requirements
- R1: After a synchronous reset, the pending register, the whole mask register (master enable included), the acknowledge strobe and the vector output all read 0.
- R2: A 1 on bit i of `int_src` in one cycle sets pending bit i at the next clock edge, and `pend_q` shows it.
- R3: When `pend_we` is high, the pending register is loaded from `pend_wdata` at the next edge. A 1 sets a bit (a software interrupt) and a 0 clears it.
- R4: `mask_we` loads the mask register. Bits 0..5 are the source enables, bit 7 is the master enable, and bit 6 always reads 0. `ei_cmd` sets bit 7 and `di_cmd` clears it. When several act on bit 7 in the same cycle, precedence from highest to lowest is: grant, `di_cmd`, `ei_cmd`, mask write.
- R5: A source is eligible only when its pending bit, its mask bit and the master enable (mask bit 7) are all 1. No grant happens while any of the three is 0.
- R6: Among eligible sources, the one with the lowest index is granted first.
- R7: The grant takes effect at the edge after the source is seen as eligible. For exactly one cycle `ack_o` is 1 and `vec_o` holds the source index. In that same cycle the source's pending bit and mask bit 7 already read 0.
- R8: The external pins map to sources as follows: `ext_pin[0]` to source 2, `ext_pin[1]` to source 0, `ext_pin[2]` to source 1.
- R9: Take a rising pin edge that falls between clock edges. The pending bit is still 0 after the first two clock edges that follow it, and reads 1 after the third.
- R10: Each rising pin edge gives exactly one pending set. Holding the pin high gives no further request, and a later fresh rising edge (after the pin has been low for at least 6 cycles) gives a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_pin | input | 3 | External request pins, rising edge sensitive |
| int_src | input | 6 | On-chip source request pulses, one bit per source |
| pend_we | input | 1 | Write strobe for the pending register |
| pend_wdata | input | 6 | Value loaded into the pending register |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | Value loaded into the mask register |
| ei_cmd | input | 1 | Enable command: sets the master enable |
| di_cmd | input | 1 | Disable command: clears the master enable |
| pend_q | output | 6 | Pending register, readable for polling |
| mask_q | output | 8 | Mask register (bit 7 is the master enable) |
| ack_o | output | 1 | One-cycle acknowledge strobe |
| vec_o | output | 3 | Index of the granted source |

## Verification
The grant path is tried with a single pending source, which shows that each of the three gating terms (pending, source mask, master) blocks on its own. It is then tried with several sources pending together, which shows the lowest-index order and that the master bit is cleared after each grant. Each external pin is pulsed alone, which tells apart both the pin-to-source mapping and a capture chain that is one stage short or one stage long. A pin held high, followed by a second edge, separates correct one-shot capture from level-sensitive or stuck capture.

// File: rtl/vint_pkg.sv
package vint_pkg;

    localparam int NUM_SRC = 6;
    localparam int NUM_EXT = 3;
    localparam int VEC_W   = $clog2(NUM_SRC);
    localparam int MASK_W  = 8;
    localparam int MEN_BIT = MASK_W - 1;

    // bits of the mask register that hold state; the rest read 0
    localparam logic [MASK_W-1:0] MASK_KEEP =
        MASK_W'((1 << MEN_BIT) | ((1 << NUM_SRC) - 1));

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [MASK_W-1:0]  mask_t;

    typedef struct packed {
        logic             hit;
        logic [VEC_W-1:0] idx;
    } grant_t;

    // which source each external pin feeds
    function automatic int ext_target(input int pin);
        case (pin)
            0:       return 2;
            1:       return 0;
            default: return 1;
        endcase
    endfunction

    // lowest set bit wins
    function automatic grant_t pick_lowest(input src_vec_t req);
        grant_t g;
        g = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                g.hit = 1'b1;
                g.idx = VEC_W'(i);
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/vint_edge_sync.sv
module vint_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic req_pulse
);
    logic cap;
    logic stg1, stg2, stg2_d;
    logic clr_q;

    // asynchronous capture of the pin edge, cleared from the clock domain
    always_ff @(posedge pin or posedge clr_q) begin
        if (clr_q) cap <= 1'b0;
        else       cap <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg1   <= 1'b0;
            stg2   <= 1'b0;
            stg2_d <= 1'b0;
            clr_q  <= 1'b1;
        end else begin
            stg1   <= cap;
            stg2   <= stg1;
            stg2_d <= stg2;
            clr_q  <= stg2;
        end
    end

    assign req_pulse = stg2 & ~stg2_d;

endmodule

// File: rtl/vint_prio_pick.sv
module vint_prio_pick
    import vint_pkg::*;
(
    input  src_vec_t req,
    output grant_t   gnt
);
    always_comb gnt = pick_lowest(req);
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
    import vint_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_EXT-1:0]  ext_pin,
    input  logic [NUM_SRC-1:0]  int_src,
    input  logic                pend_we,
    input  logic [NUM_SRC-1:0]  pend_wdata,
    input  logic                mask_we,
    input  logic [MASK_W-1:0]   mask_wdata,
    input  logic                ei_cmd,
    input  logic                di_cmd,
    output logic [NUM_SRC-1:0]  pend_q,
    output logic [MASK_W-1:0]   mask_q,
    output logic                ack_o,
    output logic [VEC_W-1:0]    vec_o
);
    logic [NUM_EXT-1:0] ext_pulse;
    src_vec_t ext_req;
    src_vec_t elig;
    grant_t   gnt;
    src_vec_t pend_nxt;
    mask_t    mask_nxt;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        vint_edge_sync u_sync (
            .clk       (clk),
            .rst       (rst),
            .pin       (ext_pin[i]),
            .req_pulse (ext_pulse[i])
        );
    end

    always_comb begin
        ext_req = '0;
        for (int i = 0; i < NUM_EXT; i++) begin
            ext_req[ext_target(i)] = ext_req[ext_target(i)] | ext_pulse[i];
        end
    end

    assign elig = pend_q & mask_q[NUM_SRC-1:0] & {NUM_SRC{mask_q[MEN_BIT]}};

    vint_prio_pick u_pick (
        .req (elig),
        .gnt (gnt)
    );

    always_comb begin
        pend_nxt = pend_we ? pend_wdata : pend_q;
        if (gnt.hit) pend_nxt[gnt.idx] = 1'b0;
        pend_nxt = pend_nxt | int_src | ext_req;
    end

    always_comb begin
        mask_nxt = mask_we ? (mask_wdata & MASK_KEEP) : mask_q;
        if (ei_cmd)  mask_nxt[MEN_BIT] = 1'b1;
        if (di_cmd)  mask_nxt[MEN_BIT] = 1'b0;
        if (gnt.hit) mask_nxt[MEN_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
            ack_o  <= 1'b0;
            vec_o  <= '0;
        end else begin
            pend_q <= pend_nxt;
            mask_q <= mask_nxt;
            ack_o  <= gnt.hit;
            if (gnt.hit) vec_o <= gnt.idx;
        end
    end

endmodule

// File: rtl/vint_ctrl_chk.sv
module vint_ctrl_chk
    import vint_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ei_cmd,
    input logic               di_cmd,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [MASK_W-1:0]  mask_q,
    input logic               ack_o,
    input logic [VEC_W-1:0]   vec_o
);
    src_vec_t el_q;
    src_vec_t below;

    always_ff @(posedge clk) begin
        if (rst) el_q <= '0;
        else     el_q <= pend_q & mask_q[NUM_SRC-1:0] & {NUM_SRC{mask_q[MEN_BIT]}};
    end

    assign below = (src_vec_t'(1) << vec_o) - src_vec_t'(1);

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o); // R7
    AST_ACK_DROPS_MASTER: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> !mask_q[MEN_BIT]); // R7
    AST_ACK_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> el_q[vec_o]); // R5
    AST_ACK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ((el_q & below) == '0)); // R6
    AST_MASTER_OFF_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        !mask_q[MEN_BIT] |=> !ack_o); // R5
    AST_DI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        di_cmd |=> !mask_q[MEN_BIT]); // R4
    AST_EI_SETS: assert property (@(posedge clk) disable iff (rst)
        (ei_cmd && !di_cmd) |=> (mask_q[MEN_BIT] || ack_o)); // R4

endmodule

bind vint_ctrl vint_ctrl_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .ei_cmd (ei_cmd),
    .di_cmd (di_cmd),
    .pend_q (pend_q),
    .mask_q (mask_q),
    .ack_o  (ack_o),
    .vec_o  (vec_o)
);

// File: tb/vint_ctrl_tb.sv
module vint_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ext_pin = '0;
    logic [5:0] int_src = '0;
    logic       pend_we = 1'b0;
    logic [5:0] pend_wdata = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       ei_cmd = 1'b0;
    logic       di_cmd = 1'b0;
    logic [5:0] pend_q;
    logic [7:0] mask_q;
    logic       ack_o;
    logic [2:0] vec_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vint_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .int_src(int_src),
        .pend_we(pend_we), .pend_wdata(pend_wdata), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
        .pend_q(pend_q), .mask_q(mask_q), .ack_o(ack_o), .vec_o(vec_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_pend(input logic [5:0] v);
        pend_we = 1'b1; pend_wdata = v;
        @(negedge clk);
        pend_we = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_we = 1'b1; mask_wdata = v;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic cmd(input logic e, input logic d);
        ei_cmd = e; di_cmd = d;
        @(negedge clk);
        ei_cmd = 1'b0; di_cmd = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(4);
        check("R1 pend", pend_q, 0);
        check("R1 mask", mask_q, 0);
        check("R1 ack", ack_o, 0);
        check("R1 vec", vec_o, 0);
        rst = 1'b0;
        idle(2);
    endtask

    task automatic t_sources();
        int_src = 6'b101000;
        @(negedge clk);
        int_src = '0;
        check("R2 int_src sets pending", pend_q, 6'b101000);
        wr_pend(6'b000110);
        check("R3 write loads pending", pend_q, 6'b000110);
        wr_pend(6'b000010);
        check("R3 write 0 clears", pend_q, 6'b000010);
        wr_pend(6'b000000);
    endtask

    task automatic t_mask();
        wr_mask(8'hFF);
        check("R4 mask write, bit6 reads 0", mask_q, 8'hBF);
        cmd(1'b0, 1'b1);
        check("R4 di clears master", mask_q, 8'h3F);
        cmd(1'b1, 1'b0);
        check("R4 ei sets master", mask_q, 8'hBF);
        cmd(1'b1, 1'b1);
        check("R4 di beats ei", mask_q, 8'h3F);
        mask_we = 1'b1; mask_wdata = 8'h00; ei_cmd = 1'b1;
        @(negedge clk);
        mask_we = 1'b0; ei_cmd = 1'b0;
        check("R4 ei beats mask write", mask_q, 8'h80);
        wr_mask(8'h00);
    endtask

    task automatic t_gate();
        wr_mask(8'h3F);
        wr_pend(6'b000100);
        idle(3);
        check("R5 master off blocks", ack_o, 0);
        check("R5 pending held", pend_q, 6'b000100);
        wr_mask(8'hBB);
        idle(3);
        check("R5 source mask blocks", ack_o, 0);
        wr_mask(8'hBF);
        check("R7 no ack before grant edge", ack_o, 0);
        @(negedge clk);
        check("R7 ack", ack_o, 1);
        check("R7 vec", vec_o, 2);
        check("R7 pending cleared", pend_q, 0);
        check("R7 master cleared", mask_q, 8'h3F);
        @(negedge clk);
        check("R7 ack one cycle", ack_o, 0);
    endtask

    task automatic t_prio();
        wr_mask(8'h3F);
        wr_pend(6'b110100);
        cmd(1'b1, 1'b0);
        @(negedge clk);
        check("R6 first grant", vec_o, 2);
        check("R6 ack first", ack_o, 1);
        check("R7 pending after first", pend_q, 6'b110000);
        cmd(1'b1, 1'b0);
        check("R7 ack dropped", ack_o, 0);
        @(negedge clk);
        check("R6 second grant", vec_o, 4);
        check("R7 pending after second", pend_q, 6'b100000);
        cmd(1'b1, 1'b0);
        @(negedge clk);
        check("R6 third grant", vec_o, 5);
        check("R7 pending empty", pend_q, 0);
        wr_mask(8'h00);
    endtask

    task automatic t_ext(input int pin, input logic [5:0] exp);
        ext_pin[pin] = 1'b1;
        idle(2);
        check("R9 not yet pending", pend_q, 0);
        @(negedge clk);
        check("R8 R9 pin sets mapped source", pend_q, exp);
        ext_pin[pin] = 1'b0;
        idle(8);
        wr_pend(6'b000000);
    endtask

    task automatic t_hold();
        ext_pin[0] = 1'b1;
        idle(3);
        check("R10 first edge", pend_q, 6'b000100);
        wr_pend(6'b000000);
        idle(10);
        check("R10 held pin no repeat", pend_q, 0);
        ext_pin[0] = 1'b0;
        idle(8);
        check("R10 falling edge no request", pend_q, 0);
        ext_pin[0] = 1'b1;
        idle(3);
        check("R10 fresh edge", pend_q, 6'b000100);
        ext_pin[0] = 1'b0;
        idle(8);
        wr_pend(6'b000000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sources();
        t_mask();
        t_gate();
        t_prio();
        t_ext(0, 6'b000100);
        t_ext(1, 6'b000001);
        t_ext(2, 6'b000010);
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule